// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is the integer arithmetic and logic unit of a simple processor datapath. It takes two operands and a 4-bit operation code and produces, with no clock, a result word plus zero, signed-overflow and carry-out flags. It performs bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than compare.

The result is built from one 1-bit slice per bit position. A ripple chain of full-adder cells produces the sum bits and carries. Each slice then uses a small multiplexer to choose between the AND, OR, sum and less inputs for its own result bit. Subtraction reuses the adder: the B operand is inverted and the carry into bit 0 is forced high. A unit at the most significant position turns the two top carries into the overflow flag. It also derives the "set" bit that drives the less input of slice 0, so set-on-less-than stays correct when the internal subtraction overflows.

Top module: `int_alu_slices`

## Requirements
- R1: With code 0000 the result is the bitwise AND of A and B.
- R2: With code 0001 the result is the bitwise OR of A and B.
- R3: With code 0010 the result is A+B modulo 2^32, and carry-out is the carry leaving bit 31.
- R4: With code 0110 the result is A-B modulo 2^32, formed as A + ~B + 1, and carry-out is 1 exactly when A >= B as unsigned numbers.
- R5: With code 0111 bit 0 of the result is 1 exactly when A < B as signed two's-complement numbers, including operand pairs whose difference overflows, and bits 31..1 are 0.
- R6: For code 0010 the overflow flag is never set when A and B differ in sign bit, and it is set when A and B share a sign bit that differs from the sign bit of the result.
- R7: For code 0110 the overflow flag is never set when A and B share a sign bit, and it is set when a negative B taken from a non-negative A gives a negative result, or a positive B taken from a negative A gives a non-negative result.
- R8: Overflow and carry-out are both 0 whenever code bits 1..0 are not 10, that is for the logic and compare codes.
- R9: The zero flag is 1 exactly when all 32 result bits are 0.
- R10: Code bits 1..0 select the slice output (00 AND, 01 OR, 10 sum, 11 less) and code bit 2 inverts B and sets the carry into bit 0. So 0100 gives A AND NOT B, and 0101 gives A OR NOT B. Code bit 3 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| ctl_i | input | 4 | Operation code |
| res_o | output | 32 | Result word |
| zero_o | output | 1 | All result bits are 0 |
| ovf_o | output | 1 | Signed overflow of add or subtract |
| cout_o | output | 1 | Carry out of bit 31 for add or subtract |

## Verification
Several checks run on every evaluation of the logic. The assertions compare the ripple chain against a plain addition, confirm that the top-position overflow appears only for same-sign effective operands whose sum changes sign, and confirm that the compare leaves bits 31..1 clear. They also confirm that add with mixed signs and subtract with equal signs never report overflow. Other behaviour can only be shown by the bench's scenarios: the compare staying correct at the overflow corners, the carry meaning of unsigned A >= B for subtraction, the zero flag on cancelling operands, the no-effect bit 3 and the inverted-B logic codes. The bench checks these against values worked out from the requirements.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  // Slice output select, taken from control bits 1..0
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (y & ci) | (x & ci);
  endfunction

endpackage

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_in_o,
  output logic             c_out_o
);
  import alu_slice_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] cy;

  // One full-adder cell per bit; carries resolved in order inside one process
  always_comb begin
    cy[0] = cin_i;
    for (int i = 0; i < WIDTH; i++) begin
      sum_o[i]  = fa_sum(a_i[i], b_i[i], cy[i]);
      cy[i+1]   = fa_carry(a_i[i], b_i[i], cy[i]);
    end
  end

  assign c_msb_in_o = cy[MSB];
  assign c_out_o    = cy[WIDTH];

  // R3 R4: the cell chain agrees with a plain wide addition
  always_comb begin
    ripple_sum_chk: assert ({c_out_o, sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("ripple chain mismatch");
  end

endmodule

// File: rtl/alu_msb_unit.sv
module alu_msb_unit (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic sum_msb_i,
  input  logic c_in_i,
  input  logic c_out_i,
  output logic ovf_o,
  output logic set_o
);

  // Overflow: carry into and out of the top cell disagree
  assign ovf_o = c_in_i ^ c_out_i;
  // Sign of the true difference: adder sign corrected by overflow
  assign set_o = sum_msb_i ^ ovf_o;

  // R6 R7: overflow only when effective operands agree in sign and the sum does not
  always_comb begin
    sign_rule_chk: assert (ovf_o == ((a_msb_i == b_msb_i) && (sum_msb_i != a_msb_i)))
      else $error("top overflow disagrees with sign rule");
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
  input  logic                      a_i,
  input  logic                      b_i,
  input  logic                      sum_i,
  input  logic                      less_i,
  input  alu_slice_pkg::slice_sel_e sel_i,
  output logic                      res_o
);
  import alu_slice_pkg::*;

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_i & b_i;
      SEL_OR:   res_o = a_i | b_i;
      SEL_SUM:  res_o = sum_i;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/int_alu_slices.sv
module int_alu_slices #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       ctl_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);
  import alu_slice_pkg::*;

  localparam int MSB = WIDTH - 1;

  slice_sel_e       sel;
  logic             b_inv;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             c_msb_in;
  logic             c_out;
  logic             ovf_raw;
  logic             set_bit;
  logic             is_arith;
  logic             unused_ctl3;

  // Control decode: bit 2 inverts B and feeds carry-in, bits 1..0 pick slice output
  assign sel         = slice_sel_e'(ctl_i[1:0]);
  assign b_inv       = ctl_i[2];
  assign b_eff       = b_inv ? ~b_i : b_i;
  assign is_arith    = (sel == SEL_SUM);
  assign unused_ctl3 = ctl_i[3];

  alu_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i        (a_i),
    .b_i        (b_eff),
    .cin_i      (b_inv),
    .sum_o      (sum),
    .c_msb_in_o (c_msb_in),
    .c_out_o    (c_out)
  );

  alu_msb_unit u_msb (
    .a_msb_i   (a_i[MSB]),
    .b_msb_i   (b_eff[MSB]),
    .sum_msb_i (sum[MSB]),
    .c_in_i    (c_msb_in),
    .c_out_i   (c_out),
    .ovf_o     (ovf_raw),
    .set_o     (set_bit)
  );

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_slice
      if (g == 0) begin : g_lsb
        alu_bit_slice u_slice (
          .a_i    (a_i[g]),
          .b_i    (b_eff[g]),
          .sum_i  (sum[g]),
          .less_i (set_bit),
          .sel_i  (sel),
          .res_o  (res_o[g])
        );
      end else begin : g_upper
        alu_bit_slice u_slice (
          .a_i    (a_i[g]),
          .b_i    (b_eff[g]),
          .sum_i  (sum[g]),
          .less_i (1'b0),
          .sel_i  (sel),
          .res_o  (res_o[g])
        );
      end
    end
  endgenerate

  assign zero_o = ~|res_o;
  assign ovf_o  = is_arith & ovf_raw;
  assign cout_o = is_arith & c_out;

  always_comb begin
    // R5
    if (sel == SEL_LESS)
      slt_upper_chk: assert (res_o[MSB:1] == '0)
        else $error("compare left upper bits set");
    // R6
    if (is_arith && !b_inv && (a_i[MSB] != b_i[MSB]))
      no_overflow_chk: assert (!ovf_o)
        else $error("overflow on mixed-sign add");
    // R7
    if (is_arith && b_inv && (a_i[MSB] == b_i[MSB]))
      no_sub_overflow_chk: assert (!ovf_o)
        else $error("overflow on same-sign subtract");
    // R8
    if (!is_arith)
      flags_quiet_chk: assert (!ovf_o && !cout_o)
        else $error("flags raised outside add/subtract");
    // R1
    if (ctl_i[2:0] == 3'b000)
      and_subset_chk: assert ((res_o & ~a_i) == '0)
        else $error("AND result outside operand A");
  end

endmodule

// File: tb/sim_int_alu_slices.sv
`timescale 1ns/1ps
module sim_int_alu_slices;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [3:0]   ctl;
    logic [W-1:0] res;
    logic         zero;
    logic         ovf;
    logic         cout;
    string        req;
  } item_t;

  logic         clk;
  logic [W-1:0] a_i, b_i, res_o;
  logic [3:0]   ctl_i;
  logic         zero_o, ovf_o, cout_o;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  item_t sb_q[$];

  int_alu_slices #(.WIDTH(W)) u0 (
    .a_i(a_i), .b_i(b_i), .ctl_i(ctl_i),
    .res_o(res_o), .zero_o(zero_o), .ovf_o(ovf_o), .cout_o(cout_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // Expected outputs written from the requirements
  function automatic item_t model(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c, string req);
    item_t it;
    logic [W:0] wide;
    it.a = a; it.b = b; it.ctl = c; it.req = req;
    it.ovf = 1'b0; it.cout = 1'b0;
    case (c[2:0])
      3'b000: it.res = a & b;
      3'b001: it.res = a | b;
      3'b100: it.res = a & ~b;
      3'b101: it.res = a | ~b;
      3'b010: begin
        wide    = {1'b0, a} + {1'b0, b};
        it.res  = wide[W-1:0];
        it.cout = wide[W];
        it.ovf  = (a[W-1] == b[W-1]) && (it.res[W-1] != a[W-1]);
      end
      3'b110: begin
        it.res  = a - b;
        it.cout = (a >= b);
        it.ovf  = (!a[W-1] && b[W-1] && it.res[W-1]) ||
                  (a[W-1] && !b[W-1] && !it.res[W-1]);
      end
      3'b111:  it.res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: it.res = '0;
    endcase
    it.zero = (it.res == '0);
    return it;
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c, string req);
    @(negedge clk);
    a_i = a; b_i = b; ctl_i = c;
    sb_q.push_back(model(a, b, c, req));
  endtask

  // Monitor: one item per rising edge, half a period after inputs settle
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t e;
      e = sb_q.pop_front();
      checks++;
      if (res_o !== e.res || zero_o !== e.zero || ovf_o !== e.ovf || cout_o !== e.cout) begin
        errors++;
        $display("FAIL %s a=%h b=%h ctl=%b: got res=%h z=%b v=%b c=%b, expected res=%h z=%b v=%b c=%b",
                 e.req, e.a, e.b, e.ctl, res_o, zero_o, ovf_o, cout_o,
                 e.res, e.zero, e.ovf, e.cout);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a_i = '0; b_i = '0; ctl_i = 4'b0000;
    // Idle state: zero operands under AND give zero result and zero flag (R9)
    drive(32'h0, 32'h0, 4'b0000, "R9 idle");
    // R1
    drive(32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0000, "R1 and");
    // R2
    drive(32'hF000_0001, 32'h0000_1000, 4'b0001, "R2 or");
    // R3 carry out and wrap to zero
    drive(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010, "R3 add carry");
    drive(32'h1234_5678, 32'h1111_1111, 4'b0010, "R3 add");
    // R6 overflow cases and mixed-sign non-overflow
    drive(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, "R6 pos+pos");
    drive(32'h8000_0000, 32'h8000_0000, 4'b0010, "R6 neg+neg");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 4'b0010, "R6 mixed");
    // R4 borrow and no-borrow, equal operands give zero (R9)
    drive(32'h0000_0007, 32'h0000_0006, 4'b0110, "R4 sub");
    drive(32'h0000_0006, 32'h0000_0007, 4'b0110, "R4 sub borrow");
    drive(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0110, "R9 sub equal");
    // R7
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0110, "R7 pos-neg");
    drive(32'h8000_0000, 32'h0000_0001, 4'b0110, "R7 neg-pos");
    drive(32'h8000_0000, 32'hFFFF_FFFF, 4'b0110, "R7 same sign");
    // R5 compare, including overflow corners
    drive(32'hFFFF_FFFD, 32'h0000_0002, 4'b0111, "R5 neg<pos");
    drive(32'h0000_0002, 32'hFFFF_FFFD, 4'b0111, "R5 pos>neg");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111, "R5 ovf corner lt");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111, "R5 ovf corner gt");
    drive(32'h0000_0005, 32'h0000_0005, 4'b0111, "R5 equal");
    // R8 flags quiet on logic and compare even when adder would carry
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0001, "R8 or");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111, "R8 slt");
    // R10 inverted-B logic and bit 3 no effect
    drive(32'hFFFF_0000, 32'hFF00_FF00, 4'b0100, "R10 and-not");
    drive(32'h0000_0000, 32'h0F0F_0F0F, 4'b0101, "R10 or-not");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 4'b1010, "R10 bit3 add");
    drive(32'h8000_0000, 32'h0000_0001, 4'b1110, "R10 bit3 sub");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 4'b1111, "R10 bit3 slt");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 4'b1000, "R10 bit3 and");
    // Mixed patterns over every supported code
    for (int n = 0; n < 400; n++) begin
      logic [3:0] codes [7] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b0100, 4'b0101};
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = (n % 5 == 0) ? ra : $urandom();
      drive(ra, rb, codes[n % 7], "R1-R10 mix");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule